// File: doc/BRIEF.md
# Stack-Machine Local-Access Execution Unit

This block is a small execution core for a processor that evaluates on a three-deep register stack (top, second, third). It fetches bytes from a program image that is fixed by parameter and held inside the block. It runs a handful of operations: push a constant, load a local word, store a local word, a zero-testing conditional branch, and a duplicate operation. A stand-alone prefix step, positive or negative, extends operands to full word width. Local words sit at word offsets from a workspace base given on an input port. They live in a single-port data memory that is also inside the block.

Loads and stores split into an address cycle and a memory cycle. The memory cycle of one of them runs in the same cycle as the address cycle (or prefix step) of the instruction that follows it, so back-to-back local accesses share cycles. The branch pops its operand only when it falls through; when it is taken, the zero stays on the stack. A registered retire strobe and a free-running cycle counter let an environment measure the cost of every instruction exactly.

Top module: `stk_local_unit`

## Requirements
- R1: While `rst_n` is low, the stack registers, instruction pointer and cycle counter read zero, no instruction retires, and no memory access is driven.
- R2: Each program byte is read as function code = bits 7:4 and data = bits 3:0. The operand is the operand register OR the data nibble. Codes: 1 positive prefix (register <= operand << 4), 2 negative prefix (register <= ~operand << 4), 3 constant, 4 load, 5 store, 6 conditional branch, 7 secondary. Every non-prefix instruction clears the operand register.
- R3: A constant instruction pushes its operand in one cycle. A push moves second to third and top to second.
- R4: A load computes address = (workspace base + operand) mod memory depth in its first cycle. In the second cycle it reads that word and pushes it.
- R5: A store spends one cycle on the same address. In the next cycle it writes the top value to that address and pops: top gets second, second gets third, and third keeps its value.
- R6: During a load or store memory cycle, a following load, store or prefix byte issues in the same cycle. A store then a load takes three cycles in total, and so does a load then a store.
- R7: A constant, branch or secondary instruction that comes straight after a load or store begins one cycle later than the memory cycle.
- R8: The memory port makes at most one access per cycle, and never a read and a write together.
- R9: A branch whose top value is zero jumps to (address of next byte + signed operand). It leaves the stack unchanged, and the following cycle is an empty refill cycle.
- R10: A branch whose top value is non-zero pops the stack and continues with the next byte after one cycle.
- R11: Duplicate is secondary operand 16, written as positive prefix 1 then secondary 0. It takes two cycles and pushes a copy of the top value.
- R12: `retire_o` is high for one cycle per completed instruction, one clock after the instruction's last cycle. At that point the stack ports show its result and `cycle_o` equals its last cycle index plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ws_ptr_i | input | WORD_W | Workspace base word address |
| retire_o | output | 1 | Instruction-completed strobe |
| cycle_o | output | CNT_W | Cycles elapsed since reset |
| a_o | output | WORD_W | Stack top |
| b_o | output | WORD_W | Stack second |
| c_o | output | WORD_W | Stack third |
| iptr_o | output | log2(PROG_MAX) | Address of next program byte |
| mem_rd_o | output | 1 | Data memory read this cycle |
| mem_wr_o | output | 1 | Data memory write this cycle |
| mem_addr_o | output | log2(DMEM_DEPTH) | Data memory word address this cycle |

## Verification
The bench builds the unit with 16-bit words, a 16-word data memory cleared at reset, and a 32-byte program image. The program exercises every instruction pairing that matters: store-load, load-store, load-load, an access followed by a constant or a branch, duplicate, prefixed constants, a fall-through branch, a forward taken branch, and a backward taken branch built with a negative prefix. Because the configuration is small, the bench can compare every cycle of the first forty against an arithmetically derived schedule. For each cycle it checks the retire strobe and the memory port operation and address, and it checks the stack contents at each retirement. This makes overlap, stall and refill timing visible down to the single cycle.

// File: rtl/slu_pkg.sv
package slu_pkg;

   localparam logic [3:0] FN_PFIX = 4'h1;
   localparam logic [3:0] FN_NFIX = 4'h2;
   localparam logic [3:0] FN_LDC  = 4'h3;
   localparam logic [3:0] FN_LDL  = 4'h4;
   localparam logic [3:0] FN_STL  = 4'h5;
   localparam logic [3:0] FN_CJ   = 4'h6;
   localparam logic [3:0] FN_OPR  = 4'h7;

   localparam int OPR_DUP = 16;

   typedef enum logic [1:0] {
      STK_HOLD = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2
   } stk_cmd_e;

endpackage

// File: rtl/slu_fetch.sv
module slu_fetch #(
   parameter int PROG_MAX = 32,
   parameter logic [8*PROG_MAX-1:0] PROG = '0,
   localparam int IW = $clog2(PROG_MAX)
)(
   input  logic [IW-1:0] iptr_i,
   output logic [7:0]    byte_o
);

   if ((1 << IW) != PROG_MAX) begin : g_bad_depth
      $error("slu_fetch: PROG_MAX must be a power of two");
   end

   logic [7:0] rom [PROG_MAX];

   for (genvar g = 0; g < PROG_MAX; g++) begin : g_rom
      assign rom[g] = PROG[8*g +: 8];
   end

   assign byte_o = rom[iptr_i];

endmodule

// File: rtl/slu_stack.sv
module slu_stack
   import slu_pkg::*;
#(
   parameter int WORD_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  stk_cmd_e          cmd_i,
   input  logic [WORD_W-1:0] push_i,
   output logic [WORD_W-1:0] a_o,
   output logic [WORD_W-1:0] b_o,
   output logic [WORD_W-1:0] c_o
);

   logic [WORD_W-1:0] a_q, b_q, c_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         c_q <= '0;
      end else begin
         unique case (cmd_i)
            STK_PUSH: begin
               c_q <= b_q;
               b_q <= a_q;
               a_q <= push_i;
            end
            STK_POP: begin
               a_q <= b_q;
               b_q <= c_q;
            end
            default: ;
         endcase
      end
   end

   assign a_o = a_q;
   assign b_o = b_q;
   assign c_o = c_q;

   // R5: a pop leaves the third register untouched
   p_pop_keeps_third_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == STK_POP) |=> (c_q == $past(c_q)) && (a_q == $past(b_q)));

   // R3: a push shifts the old values down one place
   p_push_shifts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == STK_PUSH) |=> (b_q == $past(a_q)) && (c_q == $past(b_q)));

endmodule

// File: rtl/slu_dmem.sv
module slu_dmem #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW = $clog2(DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [AW-1:0]     addr_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] rdata_o
);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("slu_dmem: DEPTH must be a power of two");
   end

   logic [WORD_W-1:0] mem_q [DEPTH];

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         end else if (wr_i) begin
            mem_q[addr_i] <= wdata_i;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (wr_i) mem_q[addr_i] <= wdata_i;
      end
   end

   assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/stk_local_unit.sv
module stk_local_unit
   import slu_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int DMEM_DEPTH = 16,
   parameter int PROG_MAX   = 32,
   parameter int CNT_W      = 32,
   parameter bit DMEM_CLEAR = 1'b1,
   parameter logic [8*PROG_MAX-1:0] PROG = '0,
   localparam int AW = $clog2(DMEM_DEPTH),
   localparam int IW = $clog2(PROG_MAX)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] ws_ptr_i,
   output logic              retire_o,
   output logic [CNT_W-1:0]  cycle_o,
   output logic [WORD_W-1:0] a_o,
   output logic [WORD_W-1:0] b_o,
   output logic [WORD_W-1:0] c_o,
   output logic [IW-1:0]     iptr_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [AW-1:0]     mem_addr_o
);

   if (WORD_W < 8) begin : g_bad_word
      $error("stk_local_unit: WORD_W must be at least 8");
   end
   if (AW > WORD_W || IW > WORD_W) begin : g_bad_span
      $error("stk_local_unit: address spans exceed the word width");
   end

   // architectural and pipeline state
   logic [IW-1:0]     iptr_q, iptr_n;
   logic [WORD_W-1:0] oreg_q, oreg_n;
   logic              mph_q, mph_n;
   logic              mph_st_q, mph_st_n;
   logic [AW-1:0]     mph_addr_q, mph_addr_n;
   logic              bubble_q;
   logic              retire_q;
   logic [CNT_W-1:0]  cyc_q;

   logic [7:0]        ibyte;
   logic [3:0]        fn;
   logic [WORD_W-1:0] val;
   logic              fn_mem, fn_pre, issue, cj_take, retire_now;
   logic [WORD_W-1:0] a_w, b_w, c_w, rdata;
   stk_cmd_e          ph_cmd, is_cmd, stk_cmd;
   logic [WORD_W-1:0] is_val, stk_val;

   slu_fetch #(.PROG_MAX(PROG_MAX), .PROG(PROG)) u_fetch (
      .iptr_i (iptr_q),
      .byte_o (ibyte)
   );

   slu_stack #(.WORD_W(WORD_W)) u_stack (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd_i  (stk_cmd),
      .push_i (stk_val),
      .a_o    (a_w),
      .b_o    (b_w),
      .c_o    (c_w)
   );

   slu_dmem #(.WORD_W(WORD_W), .DEPTH(DMEM_DEPTH), .CLEAR_ON_RESET(DMEM_CLEAR)) u_dmem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (mph_q && mph_st_q),
      .addr_i  (mph_addr_q),
      .wdata_i (a_w),
      .rdata_o (rdata)
   );

   // decode
   assign fn     = ibyte[7:4];
   assign val    = oreg_q | {{(WORD_W-4){1'b0}}, ibyte[3:0]};
   assign fn_mem = (fn == FN_LDL) || (fn == FN_STL);
   assign fn_pre = (fn == FN_PFIX) || (fn == FN_NFIX);

   // a pending memory phase lets only address-only bytes through
   assign issue   = !bubble_q && (!mph_q || fn_mem || fn_pre);
   assign cj_take = issue && (fn == FN_CJ) && (a_w == '0);

   // stack command from the memory phase
   always_comb begin
      ph_cmd = STK_HOLD;
      if (mph_q) ph_cmd = mph_st_q ? STK_POP : STK_PUSH;
   end

   // stack command from the issuing byte
   always_comb begin
      is_cmd = STK_HOLD;
      is_val = val;
      if (issue) begin
         unique case (fn)
            FN_LDC: is_cmd = STK_PUSH;
            FN_CJ:  if (a_w != '0) is_cmd = STK_POP;
            FN_OPR: if (val == WORD_W'(OPR_DUP)) begin
                       is_cmd = STK_PUSH;
                       is_val = a_w;
                    end
            default: ;
         endcase
      end
   end

   assign stk_cmd = (ph_cmd != STK_HOLD) ? ph_cmd : is_cmd;
   assign stk_val = (ph_cmd != STK_HOLD) ? rdata  : is_val;

   assign retire_now = mph_q || (issue && !fn_mem && !fn_pre);

   // next-state for fetch, operand and memory phase
   always_comb begin
      iptr_n     = iptr_q;
      oreg_n     = oreg_q;
      mph_n      = 1'b0;
      mph_st_n   = 1'b0;
      mph_addr_n = mph_addr_q;
      if (issue) begin
         iptr_n = iptr_q + IW'(1);
         unique case (fn)
            FN_PFIX: oreg_n = val << 4;
            FN_NFIX: oreg_n = (~val) << 4;
            default: oreg_n = '0;
         endcase
         if (fn_mem) begin
            mph_n      = 1'b1;
            mph_st_n   = (fn == FN_STL);
            mph_addr_n = AW'(ws_ptr_i + val);
         end
         if (cj_take) iptr_n = iptr_q + IW'(1) + val[IW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iptr_q     <= '0;
         oreg_q     <= '0;
         mph_q      <= 1'b0;
         mph_st_q   <= 1'b0;
         mph_addr_q <= '0;
         bubble_q   <= 1'b0;
         retire_q   <= 1'b0;
         cyc_q      <= '0;
      end else begin
         iptr_q     <= iptr_n;
         oreg_q     <= oreg_n;
         mph_q      <= mph_n;
         mph_st_q   <= mph_st_n;
         mph_addr_q <= mph_addr_n;
         bubble_q   <= cj_take;
         retire_q   <= retire_now;
         cyc_q      <= cyc_q + CNT_W'(1);
      end
   end

   assign retire_o   = retire_q;
   assign cycle_o    = cyc_q;
   assign a_o        = a_w;
   assign b_o        = b_w;
   assign c_o        = c_w;
   assign iptr_o     = iptr_q;
   assign mem_rd_o   = mph_q && !mph_st_q;
   assign mem_wr_o   = mph_q && mph_st_q;
   assign mem_addr_o = mph_addr_q;

   // R7: the memory phase and the issuing byte never both move the stack
   p_stack_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !((ph_cmd != STK_HOLD) && (is_cmd != STK_HOLD)));

   // R6: every memory access follows an address cycle one clock earlier
   p_mem_after_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && fn_mem) |=> (mem_rd_o || mem_wr_o));

   // R8: the port carries at most one operation per cycle
   p_single_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mem_rd_o, mem_wr_o}) <= 1);

   // R9: a taken branch is followed by an empty refill cycle
   p_refill_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cj_take |=> (!issue && !mph_q && $stable(a_w)));

   // R12: the strobe trails completion by exactly one clock
   p_retire_lag_r12: assert property (@(posedge clk) disable iff (!rst_n)
      retire_now |=> retire_o);

   // R12: the cycle counter advances by one every clock
   p_cycle_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cyc_q == $past(cyc_q) + CNT_W'(1)));

endmodule

// File: tb/stk_local_unit_tb_top.sv
`timescale 1ns/1ps
module stk_local_unit_tb_top;

   localparam int W  = 16;
   localparam int DD = 16;
   localparam int PM = 32;

   function automatic logic [8*PM-1:0] build_prog();
      logic [8*PM-1:0] p;
      p = '0;
      for (int i = 0; i < PM; i++) begin
         logic [7:0] bt;
         case (i)
            0:  bt = 8'h35;  // constant 5
            1:  bt = 8'h50;  // store off 0
            2:  bt = 8'h40;  // load off 0
            3:  bt = 8'h51;  // store off 1
            4:  bt = 8'h33;  // constant 3
            5:  bt = 8'h11;  // prefix 1
            6:  bt = 8'h70;  // duplicate
            7:  bt = 8'h41;  // load off 1
            8:  bt = 8'h40;  // load off 0
            9:  bt = 8'h62;  // branch +2 (falls through)
            10: bt = 8'h30;  // constant 0
            11: bt = 8'h61;  // branch +1 (taken to 13)
            12: bt = 8'h39;  // skipped
            13: bt = 8'h11;  // prefix 1
            14: bt = 8'h32;  // constant 0x12
            15: bt = 8'h52;  // store off 2
            16: bt = 8'h11;  // prefix 1
            17: bt = 8'h3F;  // constant 0x1F
            18: bt = 8'h30;  // constant 0
            19: bt = 8'h20;  // negative prefix
            20: bt = 8'h6D;  // branch -3 (taken to 18)
            default: bt = 8'h00;
         endcase
         p[8*i +: 8] = bt;
      end
      return p;
   endfunction

   localparam logic [8*PM-1:0] TB_PROG = build_prog();

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  ws_ptr = 16'd4;
   logic          retire;
   logic [31:0]   cyc;
   logic [W-1:0]  a, b, c;
   logic [4:0]    iptr;
   logic          mrd, mwr;
   logic [3:0]    maddr;

   int vectors = 0;
   int fails   = 0;

   always #5 clk = ~clk;

   stk_local_unit #(.WORD_W(W), .DMEM_DEPTH(DD), .PROG_MAX(PM), .CNT_W(32),
                    .DMEM_CLEAR(1'b1), .PROG(TB_PROG)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ws_ptr_i   (ws_ptr),
      .retire_o   (retire),
      .cycle_o    (cyc),
      .a_o        (a),
      .b_o        (b),
      .c_o        (c),
      .iptr_o     (iptr),
      .mem_rd_o   (mrd),
      .mem_wr_o   (mwr),
      .mem_addr_o (maddr)
   );

   task automatic chk(input string req, input int t, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, t, act, exp);
      end
   endtask

   // schedule derived from the timing rules: cycle index at which retire_o is high
   function automatic bit exp_retire(input int t);
      case (t)
         1, 3, 4, 5, 6, 8, 10, 11, 12, 13, 14, 17, 19, 20: return 1'b1;
         default: return (t >= 21) && (t % 2 == 1);
      endcase
   endfunction

   // expected memory op per cycle: 0 none, 1 read, 2 write; address in addr
   function automatic int exp_mop(input int t, output int addr);
      addr = 0;
      case (t)
         2:  begin addr = 4; return 2; end
         3:  begin addr = 4; return 1; end
         4:  begin addr = 5; return 2; end
         9:  begin addr = 5; return 1; end
         10: begin addr = 4; return 1; end
         18: begin addr = 6; return 2; end
         default: return 0;
      endcase
   endfunction

   task automatic chk_stack(input string req, input int t, input int ea, input int eb, input int ec);
      chk({req, " top"},    t, a, ea);
      chk({req, " second"}, t, b, eb);
      chk({req, " third"},  t, c, ec);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 retire", 0, retire, 0);
      chk("R1 cycle", 0, cyc, 0);
      chk("R1 iptr", 0, iptr, 0);
      chk("R1 memop", 0, {mrd, mwr}, 0);
      chk_stack("R1", 0, 0, 0, 0);
      rst_n = 1'b1;
      for (int k = 0; k < 41; k++) begin
         int t, eaddr, mop;
         @(negedge clk);
         t = int'(cyc);
         chk("R6/R7/R9/R12 retire timing", t, retire, exp_retire(t));
         mop = exp_mop(t, eaddr);
         chk("R8 read strobe", t, mrd, mop == 1);
         chk("R8 write strobe", t, mwr, mop == 2);
         if (mop != 0) chk("R4/R5 address", t, maddr, eaddr);
         case (t)
            1:  chk_stack("R3 constant", t, 5, 0, 0);
            3:  chk_stack("R5 store pop", t, 0, 0, 0);
            4:  chk_stack("R4 load push", t, 5, 0, 0);
            5:  chk_stack("R5 store pop", t, 0, 0, 0);
            6:  chk_stack("R7 constant after store", t, 3, 0, 0);
            8:  chk_stack("R11 duplicate", t, 3, 3, 0);
            10: chk_stack("R4 load", t, 5, 3, 3);
            11: chk_stack("R4 load-load", t, 5, 5, 3);
            12: begin
                   chk_stack("R10 fall-through pop", t, 5, 3, 3);
                   chk("R10 next byte", t, iptr, 10);
                end
            13: chk_stack("R3 constant zero", t, 0, 5, 3);
            14: begin
                   chk_stack("R9 taken keeps zero", t, 0, 5, 3);
                   chk("R9 forward target", t, iptr, 13);
                end
            17: chk_stack("R2 prefixed constant", t, 18, 0, 5);
            19: chk_stack("R5 store keeps third", t, 0, 5, 5);
            20: chk_stack("R2 prefix during store", t, 31, 0, 5);
            21: chk_stack("R3 constant", t, 0, 31, 0);
            23: begin
                   chk_stack("R9 taken keeps zero", t, 0, 31, 0);
                   chk("R9 backward target", t, iptr, 18);
                end
            25: chk_stack("R3 loop constant", t, 0, 0, 31);
            29: chk_stack("R3 loop constant", t, 0, 0, 0);
            default: ;
         endcase
      end
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
   end

endmodule